// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of a free-running event timer. It watches a shared main counter, which it receives as an input, and compares it with its own comparator. When the two meet, it sends a single-cycle interrupt pulse on one of several interrupt lines. In one-shot mode the comparator stays where software put it. In periodic mode the channel moves the comparator forward by a stored period after every hit, so the hits repeat at a fixed interval. The comparison can cover the full counter width or only the low register half. In the narrow width, a one-shot channel also fires when the low half of the counter rolls over from all ones to zero.

Software reaches the channel through a register port one word wide. The port has four selectable words: the mode word, a read-only capability word, and the low and high halves of the comparator. Writes are single-cycle strobes and are always accepted. Reads are combinational on the selected word. In periodic mode, a comparator write normally changes only the period. To load the comparator directly, software first sets a set-value bit in the mode word; that bit clears itself after the next write to either comparator half. A global enable gates counting decisions and pulses. A legacy routing input sends channels 0 and 1 to fixed lines 0 and 8.

Top module: `evtmr_chan`

## Requirements
- R1: After reset, the mode word (select 0) reads 0x0000C000: bit 14 is periodic-capable and bit 15 is wide-capable, and all other bits are 0. The capability word (select 1) reads 0x00000004. Both comparator halves (selects 2 and 3) read 0xFFFFFFFF. No interrupt line is active and the unsupported flag is low.
- R2: Writing the mode word with bit 3 (narrow) set clears the upper halves of the comparator and the period in the same cycle. While narrow, writes to the comparator high half (select 3) have no effect.
- R3: A write to a comparator half loads that half of the comparator only when bit 1 (periodic) is clear or bit 2 (set-value) is set. Otherwise the comparator is unchanged.
- R4: In periodic mode, a comparator low write also loads the period low half. In narrow mode, bit 31 of that value is forced to 0. A comparator high write without set-value loads the period high half with bit 31 forced to 0.
- R5: The set-value bit (mode bit 2) reads 0 after any write to either comparator half.
- R6: A match is the first cycle in which the counter equals the comparator in the active width while the global enable is high. The pulse appears on the output one clock later and lasts one cycle.
- R7: In periodic mode with a non-zero period, a hit advances the comparator by the period. In narrow mode the sum wraps modulo 2^32 and the upper half stays zero.
- R8: In narrow one-shot mode, a step of the counter's low half from 0xFFFFFFFF to 0 also fires. If that rollover and a comparator match land in the same cycle, exactly one single-cycle pulse results.
- R9: No pulse is produced unless both the channel enable (mode bit 0) and the global enable are high.
- R10: The pulse appears on exactly one line. That line is the route field (mode bits 9:5). When legacy routing is high, channel 0 uses line 0 and channel 1 uses line 8.
- R11: Writing mode bit 4 (level-trigger request) has no effect: the bit reads back 0 and the other mode fields load normally. The write sets the unsupported flag, which stays set until reset.
- R12: "Behind" means the difference comparator minus counter, taken in the active width, is zero or negative as a signed value. A periodic channel whose comparator is behind advances by one period per cycle until the comparator is ahead, without pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select: 0 mode, 1 capability, 2 comparator low, 3 comparator high |
| reg_wr_data | input | REG_W | Write data |
| reg_rd_sel | input | 2 | Read select, same encoding |
| reg_rd_data | output | REG_W | Read data of the selected word |
| main_cnt | input | 2*REG_W | Shared main counter value |
| glb_en | input | 1 | Global timer enable |
| legacy_route | input | 1 | Fixed legacy routing for channels 0 and 1 |
| irq_pulse | output | NUM_IRQ | One-hot interrupt pulse lines |
| unsup_mode | output | 1 | Sticky flag: level-trigger mode was requested |

## Verification
In narrow one-shot mode, the rollover event and a comparator match can fall in the same cycle. The bench sets up this case by writing 0 into the comparator and then stepping the counter from 0x2_FFFFFFFF to 0x3_00000000. The result is judged correct if exactly one pulse appears on the routed line in the following cycle and none appears in the cycle after. A comparator write and a periodic advance can also meet in one cycle. The bench shows that the write wins by reading the comparator back after periodic writes made without set-value.

// File: rtl/evtmr_chan_pkg.sv
package evtmr_chan_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_CAP    = 2'd1,
    SEL_CMP_LO = 2'd2,
    SEL_CMP_HI = 2'd3
  } reg_sel_e;

  localparam int B_EN       = 0;
  localparam int B_PER      = 1;
  localparam int B_SETV     = 2;
  localparam int B_NARROW   = 3;
  localparam int B_LEVEL    = 4;
  localparam int B_ROUTE_LO = 5;
  localparam int B_PCAP     = 14;
  localparam int B_WCAP     = 15;

  typedef struct packed {
    logic en;
    logic per;
    logic setv;
    logic narrow;
  } chan_mode_t;
endpackage

// File: rtl/evtmr_chan_regs.sv
module evtmr_chan_regs
  import evtmr_chan_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int RT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               adv_en,
  output chan_mode_t         mode,
  output logic [RT_W-1:0]    route,
  output logic [2*REG_W-1:0] cmp,
  output logic [2*REG_W-1:0] period,
  output logic               cmp_wr,
  output logic               unsup
);
  localparam int CNT_W = 2 * REG_W;

  logic wr_mode, wr_lo, wr_hi;
  logic [CNT_W-1:0] cmp_next;
  logic [REG_W-1:0] lo_sum;

  assign wr_mode = wr_en && (wr_sel == SEL_MODE);
  assign wr_lo   = wr_en && (wr_sel == SEL_CMP_LO);
  assign wr_hi   = wr_en && (wr_sel == SEL_CMP_HI);
  assign cmp_wr  = wr_lo || wr_hi;

  assign lo_sum   = cmp[REG_W-1:0] + period[REG_W-1:0];
  assign cmp_next = mode.narrow ? {{REG_W{1'b0}}, lo_sum} : (cmp + period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= '0;
      route  <= '0;
      cmp    <= '1;
      period <= '0;
      unsup  <= 1'b0;
    end else if (wr_mode) begin
      mode.en     <= wr_data[B_EN];
      mode.per    <= wr_data[B_PER];
      mode.setv   <= wr_data[B_SETV];
      mode.narrow <= wr_data[B_NARROW];
      route       <= wr_data[B_ROUTE_LO +: RT_W];
      if (wr_data[B_LEVEL]) unsup <= 1'b1;
      if (wr_data[B_NARROW]) begin
        cmp[CNT_W-1:REG_W]    <= '0;
        period[CNT_W-1:REG_W] <= '0;
      end
    end else if (wr_lo) begin
      if (!mode.per || mode.setv) cmp[REG_W-1:0] <= wr_data;
      if (mode.per)
        period[REG_W-1:0] <= mode.narrow ? {1'b0, wr_data[REG_W-2:0]} : wr_data;
      mode.setv <= 1'b0;
    end else if (wr_hi) begin
      if (!mode.narrow) begin
        if (!mode.per || mode.setv) cmp[CNT_W-1:REG_W] <= wr_data;
        else period[CNT_W-1:REG_W] <= {1'b0, wr_data[REG_W-2:0]};
      end
      mode.setv <= 1'b0;
    end else if (adv_en) begin
      cmp <= cmp_next;
    end
  end
endmodule

// File: rtl/evtmr_chan_match.sv
module evtmr_chan_match
  import evtmr_chan_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*REG_W-1:0] cnt,
  input  logic [2*REG_W-1:0] cmp,
  input  logic [2*REG_W-1:0] period,
  input  chan_mode_t         mode,
  input  logic               glb_en,
  input  logic               cmp_wr,
  output logic               adv_en,
  output logic               fire
);
  localparam int CNT_W = 2 * REG_W;

  logic [CNT_W-1:0] diff_w;
  logic [REG_W-1:0] diff_n;
  logic behind, per_nz, eq, eq_q, ones_q;
  logic match_evt, wrap_evt;

  assign diff_w = cmp - cnt;
  assign diff_n = cmp[REG_W-1:0] - cnt[REG_W-1:0];

  assign behind = mode.narrow ? ((diff_n == '0) || diff_n[REG_W-1])
                              : ((diff_w == '0) || diff_w[CNT_W-1]);
  assign per_nz = mode.narrow ? (|period[REG_W-1:0]) : (|period);
  assign eq     = mode.narrow ? (cnt[REG_W-1:0] == cmp[REG_W-1:0]) : (cnt == cmp);

  assign adv_en    = glb_en && mode.per && per_nz && behind;
  assign match_evt = glb_en && eq && !eq_q;
  assign wrap_evt  = glb_en && mode.narrow && !mode.per && ones_q
                     && (cnt[REG_W-1:0] == '0);
  assign fire      = (match_evt || wrap_evt) && mode.en && glb_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q   <= 1'b0;
      ones_q <= 1'b0;
    end else begin
      eq_q   <= eq && !adv_en && !cmp_wr;
      ones_q <= &cnt[REG_W-1:0];
    end
  end
endmodule

// File: rtl/evtmr_chan_route.sv
module evtmr_chan_route #(
  parameter int NUM_IRQ  = 32,
  parameter int RT_W     = 5,
  parameter int CHAN_IDX = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               legacy,
  input  logic [RT_W-1:0]    route,
  output logic [NUM_IRQ-1:0] irq
);
  localparam bit HAS_LEGACY = (CHAN_IDX < 2);
  localparam logic [RT_W-1:0] FIXED_LINE = (CHAN_IDX == 0) ? RT_W'(0) : RT_W'(8);

  logic [RT_W-1:0]    line;
  logic [NUM_IRQ-1:0] irq_d;

  assign line = (HAS_LEGACY && legacy) ? FIXED_LINE : route;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign irq_d[g] = fire && (line == RT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= '0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/evtmr_chan.sv
module evtmr_chan
  import evtmr_chan_pkg::*;
#(
  parameter int          REG_W     = 32,
  parameter int          NUM_IRQ   = 32,
  parameter int          CHAN_IDX  = 2,
  parameter logic [31:0] ROUTE_CAP = 32'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_wr_sel,
  input  logic [REG_W-1:0]   reg_wr_data,
  input  logic [1:0]         reg_rd_sel,
  output logic [REG_W-1:0]   reg_rd_data,
  input  logic [2*REG_W-1:0] main_cnt,
  input  logic               glb_en,
  input  logic               legacy_route,
  output logic [NUM_IRQ-1:0] irq_pulse,
  output logic               unsup_mode
);
  localparam int CNT_W = 2 * REG_W;
  localparam int RT_W  = $clog2(NUM_IRQ);

  chan_mode_t       mode;
  logic [RT_W-1:0]  route;
  logic [CNT_W-1:0] cmp, period;
  logic adv_en, fire, cmp_wr;
  logic chan_en, chan_setv, chan_narrow;
  logic [REG_W-1:0] cmp_hi, mode_rd;

  evtmr_chan_regs #(.REG_W(REG_W), .RT_W(RT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .adv_en(adv_en), .mode(mode), .route(route),
    .cmp(cmp), .period(period), .cmp_wr(cmp_wr), .unsup(unsup_mode)
  );

  evtmr_chan_match #(.REG_W(REG_W)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt(main_cnt), .cmp(cmp), .period(period),
    .mode(mode), .glb_en(glb_en), .cmp_wr(cmp_wr), .adv_en(adv_en), .fire(fire)
  );

  evtmr_chan_route #(.NUM_IRQ(NUM_IRQ), .RT_W(RT_W), .CHAN_IDX(CHAN_IDX)) u_route (
    .clk(clk), .rst_n(rst_n), .fire(fire), .legacy(legacy_route),
    .route(route), .irq(irq_pulse)
  );

  assign chan_en     = mode.en;
  assign chan_setv   = mode.setv;
  assign chan_narrow = mode.narrow;
  assign cmp_hi      = cmp[CNT_W-1:REG_W];

  always_comb begin
    mode_rd = '0;
    mode_rd[B_EN]     = mode.en;
    mode_rd[B_PER]    = mode.per;
    mode_rd[B_SETV]   = mode.setv;
    mode_rd[B_NARROW] = mode.narrow;
    mode_rd[B_ROUTE_LO +: RT_W] = route;
    mode_rd[B_PCAP]   = 1'b1;
    mode_rd[B_WCAP]   = 1'b1;
  end

  always_comb begin
    case (reg_rd_sel)
      SEL_MODE:   reg_rd_data = mode_rd;
      SEL_CAP:    reg_rd_data = REG_W'(ROUTE_CAP);
      SEL_CMP_LO: reg_rd_data = cmp[REG_W-1:0];
      default:    reg_rd_data = cmp_hi;
    endcase
  end
endmodule

// File: rtl/evtmr_chan_chk.sv
module evtmr_chan_chk #(
  parameter int REG_W   = 32,
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en,
  input logic               chan_en,
  input logic               chan_setv,
  input logic               chan_narrow,
  input logic [REG_W-1:0]   cmp_hi,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [NUM_IRQ-1:0] irq_pulse,
  input logic               unsup_mode
);
  p_line_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  p_glb_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (irq_pulse == '0));

  p_chan_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (irq_pulse == '0));

  p_narrow_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_narrow |-> (cmp_hi == '0));

  p_setv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[1]) |=> !chan_setv);

  p_unsup_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_mode |=> unsup_mode);
endmodule

bind evtmr_chan evtmr_chan_chk #(.REG_W(REG_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chan_en(chan_en),
  .chan_setv(chan_setv), .chan_narrow(chan_narrow), .cmp_hi(cmp_hi),
  .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .irq_pulse(irq_pulse),
  .unsup_mode(unsup_mode)
);

// File: tb/sim_evtmr_chan.sv
module sim_evtmr_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data, rd_data1;
  logic [63:0] cnt = '0;
  logic        glb = 1'b0;
  logic        legacy = 1'b0;
  logic [31:0] irq, irq1;
  logic        unsup, unsup1;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  evtmr_chan #(.CHAN_IDX(1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_sel(wr_sel),
    .reg_wr_data(wr_data), .reg_rd_sel(rd_sel), .reg_rd_data(rd_data),
    .main_cnt(cnt), .glb_en(glb), .legacy_route(legacy),
    .irq_pulse(irq), .unsup_mode(unsup)
  );

  evtmr_chan #(.CHAN_IDX(0)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_sel(wr_sel),
    .reg_wr_data(wr_data), .reg_rd_sel(rd_sel), .reg_rd_data(rd_data1),
    .main_cnt(cnt), .glb_en(glb), .legacy_route(legacy),
    .irq_pulse(irq1), .unsup_mode(unsup1)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_cnt(input logic [63:0] v, input logic [31:0] exp_irq, input string req);
    @(negedge clk);
    cnt = v;
    @(negedge clk);
    check(req, irq, exp_irq);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 mode word", d, 32'h0000C000);
    rd(2'd1, d); check("R1 capability", d, 32'h4);
    rd(2'd2, d); check("R1 cmp lo", d, 32'hFFFFFFFF);
    rd(2'd3, d); check("R1 cmp hi", d, 32'hFFFFFFFF);
    check("R1 irq idle", irq, 0);
    check("R1 unsup idle", unsup, 0);
  endtask

  task automatic t_oneshot;
    glb = 1'b1;
    wr(2'd0, 32'h61);
    wr(2'd2, 32'd100);
    wr(2'd3, 32'd0);
    tick_cnt(64'd99, 0, "R6 before match");
    tick_cnt(64'd100, 32'h8, "R6 R10 match pulse on route 3");
    @(negedge clk); check("R6 single cycle", irq, 0);
  endtask

  task automatic t_gate;
    wr(2'd0, 32'h60);
    wr(2'd2, 32'd200);
    tick_cnt(64'd200, 0, "R9 channel disabled");
    glb = 1'b0;
    wr(2'd0, 32'h61);
    wr(2'd2, 32'd300);
    tick_cnt(64'd300, 0, "R9 global disabled");
    glb = 1'b1;
    @(negedge clk); check("R9 R6 no late pulse on enable", irq, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(2'd0, 32'h67);
    wr(2'd2, 32'd1000);
    wr(2'd3, 32'd0);
    rd(2'd0, d); check("R5 set-value cleared", d, 32'h0000C063);
    tick_cnt(64'd1000, 32'h8, "R7 periodic hit");
    rd(2'd2, d); check("R7 advanced by period", d, 32'd2000);
    wr(2'd2, 32'd50);
    rd(2'd2, d); check("R3 periodic write keeps comparator", d, 32'd2000);
    tick_cnt(64'd2000, 32'h8, "R4 periodic hit");
    rd(2'd2, d); check("R4 new period loaded", d, 32'd2050);
  endtask

  task automatic t_narrow;
    logic [31:0] d;
    wr(2'd0, 32'h61);
    wr(2'd3, 32'd5);
    wr(2'd2, 32'hFFFFFFF0);
    rd(2'd3, d); check("R3 one-shot hi write", d, 32'd5);
    wr(2'd0, 32'h69);
    rd(2'd3, d); check("R2 narrow truncates", d, 32'd0);
    @(negedge clk); cnt = 64'hFFFFFF00;
    wr(2'd0, 32'h6F);
    wr(2'd2, 32'hFFFFFFF8);
    wr(2'd2, 32'h80000010);
    tick_cnt(64'hFFFFFFF8, 32'h8, "R7 narrow periodic hit");
    rd(2'd2, d); check("R4 R7 top bit cleared, wrap mod 2^32", d, 32'h8);
    rd(2'd3, d); check("R2 R7 upper stays zero", d, 32'h0);
    tick_cnt(64'h1_00000008, 32'h8, "R7 hit after wrap");
    rd(2'd2, d); check("R7 second advance", d, 32'h18);
  endtask

  task automatic t_catchup;
    logic [31:0] d;
    int pulses = 0;
    @(negedge clk); cnt = 64'h1_00000045;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq != 0) pulses++;
    end
    check("R12 catch-up without pulse", pulses, 0);
    rd(2'd2, d); check("R12 comparator ahead again", d, 32'h48);
  endtask

  task automatic t_wrap;
    wr(2'd0, 32'h69);
    tick_cnt(64'h1_FFFFFFFF, 0, "R8 before rollover");
    tick_cnt(64'h2_00000000, 32'h8, "R8 rollover pulse");
    @(negedge clk); check("R8 rollover single", irq, 0);
    tick_cnt(64'h2_00000005, 0, "R8 quiet");
    wr(2'd2, 32'd0);
    tick_cnt(64'h2_FFFFFFFF, 0, "R8 before coincident");
    tick_cnt(64'h3_00000000, 32'h8, "R8 coincident rollover and match");
    @(negedge clk); check("R8 coincident gives one pulse", irq, 0);
  endtask

  task automatic t_legacy;
    tick_cnt(64'h3_00000010, 0, "R10 quiet");
    wr(2'd2, 32'h20);
    legacy = 1'b1;
    @(negedge clk); cnt = 64'h3_00000020;
    @(negedge clk);
    check("R10 legacy channel 1 line 8", irq, 32'h100);
    check("R10 legacy channel 0 line 0", irq1, 32'h1);
    legacy = 1'b0;
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(2'd0, 32'h79);
    rd(2'd0, d); check("R11 level bit ignored", d, 32'h0000C069);
    check("R11 unsupported flag", unsup, 1);
    @(negedge clk); check("R11 flag sticky", unsup, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_oneshot;
    t_gate;
    t_periodic;
    t_narrow;
    t_catchup;
    t_wrap;
    t_legacy;
    t_level;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule